// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block produces a slower channel clock from a fast bus clock. The ratio between them is chosen per channel from a 3-bit code and runs from 2 to 4.5 in half steps. Half-step ratios need transitions that fall midway through a bus cycle. For this reason the block receives the bus clock together with its inverted phase. It registers some state on the rising edge of each. Each channel also drives an enable pulse that lasts one bus cycle and marks the bus cycle that contains a divided rising edge. Logic that runs in the bus domain can use this pulse to align itself with the slow clock.

Several channels are generated side by side, and each has its own decoder, sequencer and output stage, so their frequencies are unrelated. The block measures time in half bus periods, called slots. A divided period lasts between 4 and 9 slots. Rising-edge logic plans the output level for both slots of each bus cycle. Two toggle registers, one on each clock phase, merge into the output through an exclusive-or. As a result, each output transition comes from a single register edge and the output cannot glitch.

Top module: `clkdiv_halfstep`

## Requirements
- R1: A channel with code c has a divided period of 4+c slots, where one slot is half a bus period. Codes 0 to 5 give ratios 2, 2.5, 3, 3.5, 4 and 4.5. Codes 6 and 7 behave as code 5 (9 slots).
- R2: Each divided period starts with a rising edge. The output is high for the first ceil(T/2) slots and low for the remaining floor(T/2) slots, where T is the period in slots. The duty cycle is therefore exactly 50% at the integer ratios.
- R3: A change of code only affects a period that has not yet begun. The length of each new period is taken from the code sampled at the last rising bus edge strictly before that period begins. No period is ever shortened or stretched.
- R4: The output is held low while reset is high. After reset it stays low for one whole divided period, using the code sampled at the last reset edge. The first rising edge follows T slots after the first rising bus edge at which reset is low.
- R5: div_en is high during exactly those bus cycles, counted from rising bus edge to rising bus edge, in which the divided clock rises. This includes a rise at the mid-cycle falling bus edge. div_en is low in every other cycle, and it is low during reset and during the first held-low period.
- R6: Channels run independently. The output of one channel depends only on its own code field, which occupies bits [3k+2:3k] of ratio_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus clock |
| clk_bus_n | input | 1 | Inverted bus clock, used for mid-cycle transitions |
| rst | input | 1 | Synchronous reset, active high |
| ratio_code | input | NUM_CH*CODE_W | Per-channel ratio code, channel k in bits [3k+2:3k] |
| div_clk | output | NUM_CH | Divided clock, one bit per channel |
| div_en | output | NUM_CH | One-bus-cycle pulse for the cycle holding a divided rising edge |

## Verification
A ratio load and a divided rising edge can land in the same bus cycle. For odd slot counts the new period, and with it the rise and the enable pulse, can begin on the falling bus edge, in the same cycle in which the next code is sampled. The bench provokes this in two ways. It changes the codes on every cycle for a stretch, and elsewhere it changes them at random gaps of one to twelve cycles. The cycles in which a wrap coincides with a new code are therefore common. A behavioural slot model checks every half bus period of both channels for output level and enable. Separately, the bench measures the rise-to-rise interval of each observed period and compares it against the length of the period just ended.

// File: rtl/clkdiv_hs_pkg.sv
package clkdiv_hs_pkg;

    // Width of slot counters; holds up to 15 half-periods.
    localparam int SLOT_W = 4;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        slot_t ph;      // slot index of the slot starting at this rising edge
        slot_t per;     // length in slots of the running divided period
        logic  prime;   // first period after reset: forced low
        logic  lvl_b;   // planned level for the second slot of the cycle
        logic  en;      // cycle contains a divided rising edge
    } seq_state_t;

    function automatic slot_t half_up(input slot_t p);
        return slot_t'((int'(p) + 1) / 2);
    endfunction

endpackage

// File: rtl/clkdiv_hs_ratio_dec.sv
module clkdiv_hs_ratio_dec
    import clkdiv_hs_pkg::*;
#(
    parameter int CODE_W    = 3,
    parameter int MIN_SLOTS = 4,
    parameter int MAX_SLOTS = 9
) (
    input  logic [CODE_W-1:0] code_i,
    output slot_t             per_o
);
    localparam int SPAN = MAX_SLOTS - MIN_SLOTS;

    always_comb begin
        if (int'(code_i) >= SPAN) begin
            per_o = slot_t'(MAX_SLOTS);
        end else begin
            per_o = slot_t'(MIN_SLOTS + int'(code_i));
        end
    end
endmodule

// File: rtl/clkdiv_hs_seq.sv
module clkdiv_hs_seq
    import clkdiv_hs_pkg::*;
(
    input  logic  clk_bus,
    input  logic  rst,
    input  slot_t per_new_i,
    output logic  lvl_a_o,
    output logic  lvl_b_o,
    output logic  en_o
);
    seq_state_t state_q;
    seq_state_t state_d;
    slot_t      pb;
    slot_t      per_b;
    logic       prime_b;
    logic       lvl_a_c;

    always_comb begin
        // second slot of this cycle, with a possible period wrap
        pb      = slot_t'(state_q.ph + 1'b1);
        per_b   = state_q.per;
        prime_b = state_q.prime;
        if (slot_t'(state_q.ph + 1'b1) == state_q.per) begin
            pb      = '0;
            per_b   = per_new_i;
            prime_b = 1'b0;
        end

        lvl_a_c = !state_q.prime && (state_q.ph < half_up(state_q.per));

        state_d.lvl_b = !prime_b && (pb < half_up(per_b));
        state_d.en    = (!state_q.prime && (state_q.ph == '0)) ||
                        (!prime_b && (pb == '0));

        // first slot of next cycle, with a possible period wrap
        state_d.ph    = slot_t'(pb + 1'b1);
        state_d.per   = per_b;
        state_d.prime = prime_b;
        if (slot_t'(pb + 1'b1) == per_b) begin
            state_d.ph    = '0;
            state_d.per   = per_new_i;
            state_d.prime = 1'b0;
        end

        if (rst) begin
            state_d.ph    = '0;
            state_d.per   = per_new_i;
            state_d.prime = 1'b1;
            state_d.lvl_b = 1'b0;
            state_d.en    = 1'b0;
        end
    end

    always_ff @(posedge clk_bus) begin
        state_q <= state_d;
    end

    assign lvl_a_o = lvl_a_c;
    assign lvl_b_o = state_q.lvl_b;
    assign en_o    = state_q.en;

    // R1: the slot index stays inside the running period
    p_phase_range_r1: assert property (@(posedge clk_bus) disable iff (rst)
        state_q.ph < state_q.per);

    // R3: the period length only changes right after a wrap
    p_period_hold_r3: assert property (@(posedge clk_bus) disable iff (rst)
        !$stable(state_q.per) |-> (state_q.ph <= slot_t'(1)));

    // R5: a cycle holding a rise ends with the output high
    p_en_level_r5: assert property (@(posedge clk_bus) disable iff (rst)
        state_q.en |-> state_q.lvl_b);
endmodule

// File: rtl/clkdiv_hs_merge.sv
module clkdiv_hs_merge (
    input  logic clk_bus,
    input  logic clk_bus_n,
    input  logic rst,
    input  logic lvl_a_i,
    input  logic lvl_b_i,
    output logic div_o
);
    logic tog_p_q, tog_p_d;
    logic tog_n_q, tog_n_d;

    always_comb begin
        tog_p_d = rst ? 1'b0 : (lvl_a_i ^ tog_n_q);
        tog_n_d = rst ? 1'b0 : (lvl_b_i ^ tog_p_q);
    end

    always_ff @(posedge clk_bus) begin
        tog_p_q <= tog_p_d;
    end

    always_ff @(posedge clk_bus_n) begin
        tog_n_q <= tog_n_d;
    end

    assign div_o = tog_p_q ^ tog_n_q;

    // R2: just before each rising bus edge the output carries the planned mid-cycle level
    p_output_matches_r2: assert property (@(posedge clk_bus) disable iff (rst)
        (tog_p_q ^ tog_n_q) == lvl_b_i);
endmodule

// File: rtl/clkdiv_halfstep.sv
module clkdiv_halfstep
    import clkdiv_hs_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 3
) (
    input  logic                     clk_bus,
    input  logic                     clk_bus_n,
    input  logic                     rst,
    input  logic [NUM_CH*CODE_W-1:0] ratio_code,
    output logic [NUM_CH-1:0]        div_clk,
    output logic [NUM_CH-1:0]        div_en
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        slot_t per_new;
        logic  lvl_a;
        logic  lvl_b;

        clkdiv_hs_ratio_dec #(.CODE_W(CODE_W)) u_dec (
            .code_i (ratio_code[ch*CODE_W +: CODE_W]),
            .per_o  (per_new)
        );

        clkdiv_hs_seq u_seq (
            .clk_bus   (clk_bus),
            .rst       (rst),
            .per_new_i (per_new),
            .lvl_a_o   (lvl_a),
            .lvl_b_o   (lvl_b),
            .en_o      (div_en[ch])
        );

        clkdiv_hs_merge u_merge (
            .clk_bus   (clk_bus),
            .clk_bus_n (clk_bus_n),
            .rst       (rst),
            .lvl_a_i   (lvl_a),
            .lvl_b_i   (lvl_b),
            .div_o     (div_clk[ch])
        );
    end
endmodule

// File: tb/clkdiv_halfstep_tb.sv
`timescale 1ns/1ps
module clkdiv_halfstep_tb;
    localparam int NUM_CH = 2;
    localparam int CODE_W = 3;

    logic                     clk = 1'b0;
    logic                     clk_n;
    logic                     rst = 1'b1;
    logic [NUM_CH*CODE_W-1:0] code = '0;
    logic [NUM_CH-1:0]        div_clk;
    logic [NUM_CH-1:0]        div_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_chg = -100;

    always #2.5 clk = ~clk;
    assign clk_n = ~clk;

    clkdiv_halfstep #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dut (
        .clk_bus(clk), .clk_bus_n(clk_n), .rst(rst),
        .ratio_code(code), .div_clk(div_clk), .div_en(div_en));

    task automatic chk(input string req, input int ch, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d t=%0t got=%b exp=%b", req, ch, $time, got, exp);
        end
    endtask

    task automatic chk_int(input string req, input int ch, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s ch%0d t=%0t got=%0d exp=%0d", req, ch, $time, got, exp);
        end
    endtask

    function automatic int dec(input int c);
        return (c >= 5) ? 9 : 4 + c;
    endfunction

    // behavioural slot model
    int   m_pos[NUM_CH];
    int   m_per[NUM_CH];
    bit   m_prime[NUM_CH];
    bit   m_prev[NUM_CH];
    bit   m_a[NUM_CH];
    bit   m_b[NUM_CH];
    bit   m_en[NUM_CH];
    int   m_endlen[NUM_CH];
    int   slot_no = 0;
    int   o_last_rise[NUM_CH];
    bit   o_prev[NUM_CH];
    int   exp_len[NUM_CH];
    bit   armed = 1'b0;
    bit   in_rst = 1'b1;

    function automatic bit lvl(input int ch);
        return !m_prime[ch] && (m_pos[ch] < (m_per[ch] + 1) / 2);
    endfunction

    task automatic adv(input int ch, input int c);
        m_pos[ch]++;
        if (m_pos[ch] == m_per[ch]) begin
            m_endlen[ch] = m_prime[ch] ? -1 : m_per[ch];
            m_pos[ch]    = 0;
            m_prime[ch]  = 1'b0;
            m_per[ch]    = dec(c);
        end
    endtask

    function automatic string lbl(input int ch);
        if (in_rst || m_prime[ch]) return "R4";
        if (cyc - last_chg < 12) return "R3";
        return (ch == 0) ? "R2" : "R6";
    endfunction

    // observed period measurement (R1)
    task automatic observe(input int ch, input bit model_rise);
        if (model_rise) exp_len[ch] = m_endlen[ch];
        if (div_clk[ch] && !o_prev[ch]) begin
            if (o_last_rise[ch] >= 0 && exp_len[ch] > 0)
                chk_int("R1", ch, slot_no - o_last_rise[ch], exp_len[ch]);
            o_last_rise[ch] = slot_no;
        end
        o_prev[ch] = div_clk[ch];
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            in_rst = rst;
            for (int ch = 0; ch < NUM_CH; ch++) begin
                int c;
                c = int'(code[ch*CODE_W +: CODE_W]);
                if (rst) begin
                    m_pos[ch] = 0; m_per[ch] = dec(c); m_prime[ch] = 1'b1;
                    m_a[ch] = 1'b0; m_b[ch] = 1'b0; m_en[ch] = 1'b0; m_prev[ch] = 1'b0;
                    o_last_rise[ch] = -1; exp_len[ch] = -1;
                end else begin
                    m_a[ch] = lvl(ch);
                    adv(ch, c);
                    m_b[ch] = lvl(ch);
                    adv(ch, c);
                    m_en[ch] = (m_a[ch] && !m_prev[ch]) || (m_b[ch] && !m_a[ch]);
                    m_prev[ch] = m_b[ch];
                end
            end
            #1.25;
            slot_no++;
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (armed) begin
                    chk(lbl(ch), ch, div_clk[ch], m_a[ch]);
                    chk("R5", ch, div_en[ch], m_en[ch]);
                    observe(ch, m_a[ch] && !o_prev[ch] && m_en[ch]);
                end
            end
            @(negedge clk);
            #1.25;
            slot_no++;
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (armed) begin
                    chk(lbl(ch), ch, div_clk[ch], m_b[ch]);
                    observe(ch, m_b[ch] && !m_a[ch]);
                end
            end
            armed = 1'b1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_codes(input int c0, input int c1);
        code[0 +: CODE_W]      = CODE_W'(c0);
        code[CODE_W +: CODE_W] = CODE_W'(c1);
        last_chg = cyc;
    endtask

    initial begin
        set_codes(0, 5);
        tick(4);
        rst = 1'b0;
        // R1, R2, R6: every code held steady, channels at different ratios
        for (int c = 0; c < 8; c++) begin
            set_codes(c, 7 - c);
            tick(40);
        end
        // R3, R5: code changes on every cycle, colliding with wraps
        for (int i = 0; i < 300; i++) begin
            set_codes($urandom_range(7), $urandom_range(7));
            tick(1);
        end
        // R4: reset in the middle of a run
        set_codes(3, 1);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(60);
        // R3: random spacing between changes
        for (int i = 0; i < 120; i++) begin
            set_codes($urandom_range(7), $urandom_range(7));
            tick($urandom_range(1, 12));
        end
        tick(20);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule